// File: doc/BRIEF.md
# Column-Associative Cache Controller

This block is a read-only cache controller that manages a direct-mapped line store but probes it up to twice per request. A request's first probe goes to its home line, chosen by the low address bits. If that probe misses, a second probe may go to a partner line whose index differs only in the most significant index bit. A hit at home answers in a single cycle. A hit at the partner costs one extra cycle, and the two lines are then exchanged so that the most recently used line sits at home. The aim is close to two-way hit ratios while keeping the one-cycle hit path of a direct-mapped array.

Each line holds a valid bit, a "displaced" bit, the full block address as its tag, and one data word. The displaced bit is set when a line sits at its partner index rather than its home index. Suppose a home probe misses on a line whose displaced bit is set. The partner cannot hold the wanted address, so the second probe is skipped and the home line is replaced at once.

When both probes miss, the block requests the line from a memory model over a valid/response handshake. The fetched line goes to the home slot, the previous home occupant moves to the partner slot, and the previous partner occupant is dropped.

Top module: `ca_cache`

## Requirements
- R1: After reset every line is invalid: `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the first access to any address misses.
- R2: The home index of an address is `addr[IDX_W-1:0]`. The partner index is the home index with bit `IDX_W-1` inverted.
- R3: A home hit asserts `rsp_valid` one cycle after the request is accepted, with `rsp_hit`=1, `rsp_second`=0 and the line's data.
- R4: A partner hit responds two cycles after acceptance with `rsp_hit`=1 and `rsp_second`=1. The two lines are then exchanged: the same address next hits at home, and the former home address now hits at the partner.
- R5: When both probes miss, `mem_req_valid` is raised with the requested address. One cycle after `mem_rsp_valid`, the block responds with `rsp_hit`=0 and the memory data. The new line takes the home slot, the previous home line moves to the partner slot, and the previous partner line is lost.
- R6: If the home line misses, is valid and has its displaced bit set, no partner probe is made. `mem_req_valid` is already high one cycle after acceptance. Only the home line is replaced, and the partner slot is left unchanged.
- R7: A line written into its home slot has its displaced bit cleared. A line moved into its partner slot has the bit set. So a later home miss on it skips, or does not skip, the partner probe accordingly.
- R8: `req_ready` is low while a partner probe or a refill is in progress. A request presented then is ignored and produces no response.
- R9: Tags hold the full block address. Two addresses sharing an index, or an address meeting a displaced line of another home, never produce a false hit.
- R10: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_rsp_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Block address of the request |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_hit | output | 1 | 1 if found by either probe, 0 if refilled |
| rsp_second | output | 1 | 1 if found by the partner probe |
| rsp_data | output | DATA_W | Data word returned |
| mem_req_valid | output | 1 | Refill request to memory |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| mem_rsp_valid | input | 1 | Memory data strobe |
| mem_rsp_data | input | DATA_W | Fetched data word |

## Verification
Two things can land in the same cycle. One is the write that finishes a partner-hit exchange or a refill. The other is the home lookup of the next request, presented in the very cycle its predecessor's response appears. The bench always issues its next request in that cycle. After an exchange or a refill, it checks the follow-on access for its latency, its probe flag and its data word. This shows that the lookup saw the rewritten home and partner slots, not the old ones.

// File: rtl/ca_pkg.sv
package ca_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE2 = 2'd1,
    ST_FILL   = 2'd2
  } ca_state_e;

endpackage

// File: rtl/ca_match.sv
module ca_match #(
  parameter int TAG_W = 16
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] look_addr,
  output logic             hit
);

  assign hit = line_valid && (line_tag == look_addr);

endmodule

// File: rtl/ca_store.sv
module ca_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  output logic              a_valid,
  output logic              a_rehash,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  output logic              b_valid,
  output logic              b_rehash,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wa_en,
  input  logic              wa_valid,
  input  logic              wa_rehash,
  input  logic [TAG_W-1:0]  wa_tag,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic              wb_valid,
  input  logic              wb_rehash,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data
);

  localparam int LINES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(1) << (IDX_W - 1);

  logic              valid_q  [LINES];
  logic              rehash_q [LINES];
  logic [TAG_W-1:0]  tag_q    [LINES];
  logic [DATA_W-1:0] data_q   [LINES];

  // per-line control flops carry the reset; payload arrays do not
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i]  <= 1'b0;
        rehash_q[i] <= 1'b0;
      end else if (wa_en && (idx_a == IDX_W'(i))) begin
        valid_q[i]  <= wa_valid;
        rehash_q[i] <= wa_rehash;
      end else if (wb_en && (idx_b == IDX_W'(i))) begin
        valid_q[i]  <= wb_valid;
        rehash_q[i] <= wb_rehash;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wa_en) begin
      tag_q[idx_a]  <= wa_tag;
      data_q[idx_a] <= wa_data;
    end
    if (wb_en) begin
      tag_q[idx_b]  <= wb_tag;
      data_q[idx_b] <= wb_data;
    end
  end

  assign a_valid  = valid_q[idx_a];
  assign a_rehash = rehash_q[idx_a];
  assign a_tag    = tag_q[idx_a];
  assign a_data   = data_q[idx_a];
  assign b_valid  = valid_q[idx_b];
  assign b_rehash = rehash_q[idx_b];
  assign b_tag    = tag_q[idx_b];
  assign b_data   = data_q[idx_b];

  // R2: the two ports always address a home/partner pair
  p_pair_index_r2: assert property (@(posedge clk) disable iff (rst)
    (wa_en || wb_en) |-> (idx_b == (idx_a ^ TOP_BIT)));

  // R7: a line written into its home slot is valid and not displaced
  p_home_clean_r7: assert property (@(posedge clk) disable iff (rst)
    wa_en |=> (valid_q[$past(idx_a)] && !rehash_q[$past(idx_a)]));

endmodule

// File: rtl/ca_ctrl.sv
module ca_ctrl
  import ca_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_second,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [IDX_W-1:0]  home_idx,
  output logic [IDX_W-1:0]  part_idx,
  output logic [ADDR_W-1:0] look_addr,
  input  logic              home_hit,
  input  logic              part_hit,
  input  logic              home_valid,
  input  logic              home_rehash,
  input  logic [ADDR_W-1:0] home_tag,
  input  logic [DATA_W-1:0] home_data,
  input  logic              part_valid,
  input  logic              part_rehash,
  input  logic [ADDR_W-1:0] part_tag,
  input  logic [DATA_W-1:0] part_data,
  output logic              wa_en,
  output logic              wa_valid,
  output logic              wa_rehash,
  output logic [ADDR_W-1:0] wa_tag,
  output logic [DATA_W-1:0] wa_data,
  output logic              wb_en,
  output logic              wb_valid,
  output logic              wb_rehash,
  output logic [ADDR_W-1:0] wb_tag,
  output logic [DATA_W-1:0] wb_data
);

  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(1) << (IDX_W - 1);

  ca_state_e         state_q;
  logic [ADDR_W-1:0] lat_q;
  logic              skip_q;
  logic              accept;

  assign look_addr     = (state_q == ST_IDLE) ? req_addr : lat_q;
  assign home_idx      = look_addr[IDX_W-1:0];
  assign part_idx      = home_idx ^ TOP_BIT;
  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state_q == ST_FILL);
  assign mem_req_addr  = lat_q;

  // store write commands: port a = home slot, port b = partner slot
  always_comb begin
    wa_en     = 1'b0;
    wa_valid  = 1'b1;
    wa_rehash = 1'b0;
    wa_tag    = lat_q;
    wa_data   = mem_rsp_data;
    wb_en     = 1'b0;
    wb_valid  = home_valid;
    wb_rehash = 1'b1;
    wb_tag    = home_tag;
    wb_data   = home_data;
    case (state_q)
      ST_PROBE2: begin
        if (part_hit) begin
          wa_en   = 1'b1;
          wa_tag  = part_tag;
          wa_data = part_data;
          wb_en   = 1'b1;
        end
      end
      ST_FILL: begin
        if (mem_rsp_valid) begin
          wa_en = 1'b1;
          wb_en = !skip_q && home_valid;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      lat_q      <= '0;
      skip_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_second <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            lat_q <= req_addr;
            if (home_hit) begin
              rsp_valid  <= 1'b1;
              rsp_hit    <= 1'b1;
              rsp_second <= 1'b0;
              rsp_data   <= home_data;
            end else if (home_valid && home_rehash) begin
              skip_q  <= 1'b1;
              state_q <= ST_FILL;
            end else begin
              skip_q  <= 1'b0;
              state_q <= ST_PROBE2;
            end
          end
        end
        ST_PROBE2: begin
          if (part_hit) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b1;
            rsp_second <= 1'b1;
            rsp_data   <= part_data;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rsp_valid) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_second <= 1'b0;
            rsp_data   <= mem_rsp_data;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: refill request held with a steady address until answered
  p_fill_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8: nothing is captured while the request port is closed
  p_no_capture_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(lat_q));

  // R7: a line found by the partner probe must be marked displaced
  p_partner_marked_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PROBE2 && part_hit) |-> (part_valid && part_rehash));

endmodule

// File: rtl/ca_cache.sv
module ca_cache #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_second,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  logic [IDX_W-1:0]  home_idx, part_idx;
  logic [ADDR_W-1:0] look_addr;
  logic              home_hit, part_hit;
  logic              home_valid, home_rehash, part_valid, part_rehash;
  logic [ADDR_W-1:0] home_tag, part_tag;
  logic [DATA_W-1:0] home_data, part_data;
  logic              wa_en, wa_valid, wa_rehash, wb_en, wb_valid, wb_rehash;
  logic [ADDR_W-1:0] wa_tag, wb_tag;
  logic [DATA_W-1:0] wa_data, wb_data;

  ca_store #(.IDX_W(IDX_W), .TAG_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .idx_a(home_idx), .idx_b(part_idx),
    .a_valid(home_valid), .a_rehash(home_rehash), .a_tag(home_tag), .a_data(home_data),
    .b_valid(part_valid), .b_rehash(part_rehash), .b_tag(part_tag), .b_data(part_data),
    .wa_en(wa_en), .wa_valid(wa_valid), .wa_rehash(wa_rehash), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(wb_en), .wb_valid(wb_valid), .wb_rehash(wb_rehash), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  ca_match #(.TAG_W(ADDR_W)) u_match_home (
    .line_valid(home_valid), .line_tag(home_tag), .look_addr(look_addr), .hit(home_hit)
  );

  ca_match #(.TAG_W(ADDR_W)) u_match_part (
    .line_valid(part_valid), .line_tag(part_tag), .look_addr(look_addr), .hit(part_hit)
  );

  ca_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_second(rsp_second), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .home_idx(home_idx), .part_idx(part_idx), .look_addr(look_addr),
    .home_hit(home_hit), .part_hit(part_hit),
    .home_valid(home_valid), .home_rehash(home_rehash), .home_tag(home_tag), .home_data(home_data),
    .part_valid(part_valid), .part_rehash(part_rehash), .part_tag(part_tag), .part_data(part_data),
    .wa_en(wa_en), .wa_valid(wa_valid), .wa_rehash(wa_rehash), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(wb_en), .wb_valid(wb_valid), .wb_rehash(wb_rehash), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  // R3: a home hit answers in the cycle after acceptance
  p_fast_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit && !rsp_second) |-> $past(req_valid && req_ready));

  // R4: a partner hit never answers in the cycle after acceptance
  p_partner_slow_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_second) |-> !$past(req_ready));

  // R5: a refill response follows the memory answer
  p_fill_after_mem_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> $past(mem_rsp_valid));

endmodule

// File: tb/tb_ca_cache.sv
module tb_ca_cache;

  localparam int ADDR_W  = 16;
  localparam int IDX_W   = 3;
  localparam int DATA_W  = 32;
  localparam int MEM_LAT = 3;

  localparam int K_HOME = 0;
  localparam int K_PART = 1;
  localparam int K_MISS = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic              rsp_valid, rsp_hit, rsp_second;
  logic [DATA_W-1:0] rsp_data;
  logic              mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ca_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_second(rsp_second), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory model; R10 stability checked on every waiting cycle
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [ADDR_W-1:0] a;
        a = mem_req_addr;
        for (int w = 0; w < MEM_LAT - 1; w++) begin
          @(negedge clk);
          chk("R10", "mem_req_valid held", {63'd0, mem_req_valid}, 64'd1);
          chk("R10", "mem_req_addr stable", {48'd0, mem_req_addr}, {48'd0, a});
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // called at a negedge with the controller idle; returns at the response negedge
  task automatic do_req(input logic [ADDR_W-1:0] a, output int cyc, output bit hit,
                        output bit sec, output logic [DATA_W-1:0] data, output bit early_mem);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    early_mem = mem_req_valid;
    while (!rsp_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    hit  = rsp_hit;
    sec  = rsp_second;
    data = rsp_data;
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input int kind,
                        input string rq, input int exp_early);
    int cyc; bit hit, sec, early; logic [DATA_W-1:0] data;
    do_req(a, cyc, hit, sec, data, early);
    chk(rq, "response seen", {63'd0, rsp_valid}, 64'd1);
    chk(rq, "rsp_hit", {63'd0, hit}, {63'd0, kind != K_MISS});
    chk(rq, "rsp_second", {63'd0, sec}, {63'd0, kind == K_PART});
    chk(rq, "rsp_data", {32'd0, data}, {32'd0, mem_word(a)});
    if (kind == K_HOME) chk(rq, "home-hit latency", 64'(cyc), 64'd1);
    if (kind == K_PART) chk(rq, "partner-hit latency", 64'(cyc), 64'd2);
    if (kind == K_MISS) chk(rq, "miss latency above 2", {63'd0, cyc > 2}, 64'd1);
    if (exp_early >= 0) chk(rq, "early refill request", {63'd0, early}, 64'(exp_early));
  endtask

  localparam logic [ADDR_W-1:0] A = 16'h0010;  // home 0
  localparam logic [ADDR_W-1:0] B = 16'h0020;  // home 0
  localparam logic [ADDR_W-1:0] C = 16'h0030;  // home 0
  localparam logic [ADDR_W-1:0] D = 16'h0044;  // home 4
  localparam logic [ADDR_W-1:0] E = 16'h0014;  // home 4
  localparam logic [ADDR_W-1:0] F = 16'h0025;  // home 5

  task automatic t_reset;
    chk("R1", "req_ready after reset", {63'd0, req_ready}, 64'd1);
    chk("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    chk("R1", "mem_req_valid after reset", {63'd0, mem_req_valid}, 64'd0);
    access(A, K_MISS, "R1 cold miss", 0);
  endtask

  task automatic t_home_hit;
    access(A, K_HOME, "R3 R2 home hit", -1);
  endtask

  task automatic t_displace;
    // B shares home 0 with A; A moves to slot 4 marked displaced
    access(B, K_MISS, "R5 R9 fill same index", 0);
  endtask

  task automatic t_partner;
    access(A, K_PART, "R4 partner hit", -1);
    access(A, K_HOME, "R4 swapped to home", -1);
    access(B, K_PART, "R4 former home at partner", -1);
  endtask

  task automatic t_evict;
    // A at slot 4, B at home; C misses both: B to slot 4, A evicted
    access(C, K_MISS, "R5 R7 probe partner", 0);
    access(B, K_PART, "R5 old home moved", -1);
    access(A, K_MISS, "R5 old partner evicted", 0);
  endtask

  task automatic t_skip;
    // slot 4 holds B marked displaced: D skips partner probe
    access(D, K_MISS, "R6 R7 skip partner probe", 1);
    access(A, K_HOME, "R6 partner slot untouched", -1);
    access(B, K_MISS, "R6 displaced line replaced", 0);
    // slot 4 now A displaced: E must not false-hit
    access(E, K_MISS, "R9 no false hit on displaced", 1);
    access(B, K_HOME, "R9 home kept", -1);
    access(E, K_HOME, "R9 new line at home", -1);
  endtask

  task automatic t_busy;
    int cyc; logic [DATA_W-1:0] got; bit seen;
    req_valid = 1'b1;
    req_addr  = F;
    @(posedge clk);
    @(negedge clk);
    chk("R8", "ready low while busy", {63'd0, req_ready}, 64'd0);
    req_addr = E;  // would be a home hit if taken
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 2;
    while (!rsp_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    got = rsp_data;
    chk("R8", "response for first request", {32'd0, got}, {32'd0, mem_word(F)});
    chk("R8", "first request missed", {63'd0, rsp_hit}, 64'd0);
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (rsp_valid) seen = 1'b1;
    end
    chk("R8", "ignored request gave no response", {63'd0, seen}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_home_hit();
    t_displace();
    t_partner();
    t_evict();
    t_skip();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule